// File: doc/BRIEF.md
# Per-Port Traffic Rate Limiter

This block polices one port's traffic against a configured rate. A 7-bit rate code, a mode select (bit rate or packet rate) and a link-speed select (10/100 or gigabit) give an allowance of bytes, and in packet mode also of packets, for each measurement window. The window boundary comes from an external pulse, `win_tick`. The parameter `WINDOW_US` gives the window length that the pulse stands for. All allowances are computed with integer arithmetic and rounded down.

For each frame start the block receives the frame's byte length. One cycle later it returns a pass or drop decision. A passed frame is added to the window's counters. A dropped frame leaves them as they were.

A three-state machine controls the block. `ST_LOAD` latches the decoded allowance and the configuration and clears the counters. It is entered after reset and whenever the configuration changes. From `ST_LOAD` the machine moves to `ST_BYPASS` when the code means "no limit", and to `ST_OPEN` otherwise. In `ST_OPEN` frames are policed. From `ST_OPEN` or `ST_BYPASS`, any difference between the live configuration and the latched one returns the machine to `ST_LOAD`.

Top module: `port_rate_limiter`

## Requirements
- R1: With rate code 0 the block is in ST_BYPASS and every frame passes, whatever its length.
- R2: In bit mode, codes 1 to 100 set a rate of code x 1000 kbps at 10/100 speed and code x 10000 kbps at gigabit speed. The byte allowance is kbps x WINDOW_US / 8000, rounded down.
- R3: In bit mode, codes 101 to 113 set a rate of (code-100) x 64 kbps at 10/100 speed and (code-100) x 640 kbps at gigabit speed. The same byte conversion as in R2 applies.
- R4: A frame passes only if the bytes already counted in the window plus its length are at most the byte allowance. Reaching the allowance exactly passes. A frame longer than the whole allowance is dropped.
- R5: In packet mode, codes 101 to 113 set 64 pps for (code-100)=1 and (code-100-1) x 128 pps above that, times 10 at gigabit speed. The packet allowance is pps x WINDOW_US / 1000000, rounded down.
- R6: In packet mode, each code also carries a paired bit rate, which is the R2/R3 rate for the same code and speed. A frame passes only if both the packet count and the byte count stay within their allowances.
- R7: In packet mode, codes 1 to 100 set code x 1920 pps at 10/100 speed and code x 19200 pps at gigabit speed.
- R8: A dropped frame leaves the window's byte and packet counters unchanged.
- R9: A `win_tick` pulse clears both counters. A frame in the same cycle as the pulse is judged against an empty window and then counted in it.
- R10: Codes 114 to 127 behave as code 0 (no limit).
- R11: After reset, and after any change of code, mode or speed, the block spends one cycle in ST_LOAD. In that cycle the counters are cleared and the new allowance is latched. A frame presented in that cycle is dropped.
- R12: Reset clears `dec_valid` and `dec_pass`. Each `frm_valid` gives `dec_valid` high in the next cycle, with `dec_pass` carrying the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_tick | input | 1 | One-cycle pulse marking a window boundary |
| rate_code | input | 7 | Rate code (static configuration) |
| pkt_mode | input | 1 | 1 = packet-rate mode, 0 = bit-rate mode |
| gig_speed | input | 1 | 1 = gigabit link, 0 = 10/100 link |
| frm_valid | input | 1 | Frame start, one cycle per frame |
| frm_len | input | LEN_W | Frame length in bytes, valid with frm_valid |
| dec_valid | output | 1 | Decision valid, one cycle after frm_valid |
| dec_pass | output | 1 | 1 = frame admitted, 0 = dropped |

## Verification
The hardest case to reach is a window boundary that lands on a frame start while the window is already full. The frame must be judged against the cleared counters, not the full ones.

The stimulus fills a 1 Mbps window with 1000-byte frames until one is dropped. It then raises `win_tick` together with the next frame and expects a pass, followed by exactly eleven more passes. The packet-mode cases pick lengths so that the byte bound binds in one case (code 102) and the packet bound binds in another (code 101). This separates the two limits of R6.

// File: rtl/rl_pkg.sv
package rl_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_BYPASS = 2'd2
    } rl_state_e;

    localparam int unsigned CODE_W = 7;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              pkt_mode;
        logic              gig;
    } rl_cfg_t;

    localparam int unsigned COARSE_LAST   = 100;
    localparam int unsigned FINE_LAST     = 113;
    localparam int unsigned KBPS_PER_UNIT = 1000;
    localparam int unsigned KBPS_FINE     = 64;
    localparam int unsigned PPS_COARSE    = 1920;
    localparam int unsigned PPS_FIRST     = 64;
    localparam int unsigned PPS_FINE      = 128;
    localparam int unsigned GIG_SCALE     = 10;

endpackage

// File: rtl/rl_code_decode.sv
module rl_code_decode
    import rl_pkg::*;
(
    input  rl_cfg_t     cfg,
    output logic        unlimited,
    output logic [31:0] kbps,
    output logic [31:0] pps
);

    logic [31:0] n;
    logic [31:0] sc;
    logic [31:0] f;

    always_comb begin
        n         = 32'(cfg.code);
        sc        = cfg.gig ? 32'(GIG_SCALE) : 32'd1;
        f         = n - 32'(COARSE_LAST);
        unlimited = 1'b0;
        kbps      = '0;
        pps       = '0;
        if (n == 32'd0 || n > 32'(FINE_LAST)) begin
            unlimited = 1'b1;
        end else if (n <= 32'(COARSE_LAST)) begin
            kbps = n * 32'(KBPS_PER_UNIT) * sc;
            pps  = n * 32'(PPS_COARSE) * sc;
        end else begin
            kbps = f * 32'(KBPS_FINE) * sc;
            pps  = (f == 32'd1) ? 32'(PPS_FIRST) * sc
                                : (f - 32'd1) * 32'(PPS_FINE) * sc;
        end
    end

endmodule

// File: rtl/rl_allow_conv.sv
module rl_allow_conv #(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned WINDOW_US = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [31:0]      kbps,
    input  logic [31:0]      pps,
    output logic [CNT_W-1:0] byte_allow,
    output logic [CNT_W-1:0] pkt_allow
);

    localparam logic [63:0] CNT_MAX  = (64'd1 << CNT_W) - 64'd1;
    localparam logic [63:0] WIN      = 64'(WINDOW_US);
    localparam logic [63:0] BIT_DIV  = 64'd8000;
    localparam logic [63:0] PKT_DIV  = 64'd1000000;

    logic [63:0] b_full;
    logic [63:0] p_full;
    logic [CNT_W-1:0] b_sat;
    logic [CNT_W-1:0] p_sat;

    always_comb begin
        b_full = (64'(kbps) * WIN) / BIT_DIV;
        p_full = (64'(pps) * WIN) / PKT_DIV;
        b_sat  = (b_full > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : b_full[CNT_W-1:0];
        p_sat  = (p_full > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : p_full[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_allow <= '0;
            pkt_allow  <= '0;
        end else if (load) begin
            byte_allow <= b_sat;
            pkt_allow  <= p_sat;
        end
    end

endmodule

// File: rtl/rl_window_ctr.sv
module rl_window_ctr #(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             win_open,
    input  logic             win_bypass,
    input  logic             chk_pkt,
    input  logic             tick,
    input  logic             frm_valid,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [CNT_W-1:0] byte_allow,
    input  logic [CNT_W-1:0] pkt_allow,
    output logic             dec_valid,
    output logic             dec_pass
);

    localparam int unsigned SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W-1:0] pkt_cnt;
    logic [CNT_W-1:0] base_b;
    logic [CNT_W-1:0] base_p;
    logic [SUM_W-1:0] sum_b;
    logic [SUM_W-1:0] sum_p;
    logic             fits;
    logic             admit;

    always_comb begin
        base_b = tick ? '0 : byte_cnt;
        base_p = tick ? '0 : pkt_cnt;
        sum_b  = SUM_W'(base_b) + SUM_W'(frm_len);
        sum_p  = SUM_W'(base_p) + SUM_W'(1);
        fits   = (sum_b <= SUM_W'(byte_allow)) &&
                 (!chk_pkt || (sum_p <= SUM_W'(pkt_allow)));
        admit  = frm_valid && (win_bypass || (win_open && fits));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt  <= '0;
            pkt_cnt   <= '0;
            dec_valid <= 1'b0;
            dec_pass  <= 1'b0;
        end else begin
            dec_valid <= frm_valid;
            if (clear) begin
                byte_cnt <= '0;
                pkt_cnt  <= '0;
                dec_pass <= 1'b0;
            end else begin
                dec_pass <= admit;
                if (admit && win_open) begin
                    byte_cnt <= sum_b[CNT_W-1:0];
                    pkt_cnt  <= sum_p[CNT_W-1:0];
                end else if (tick) begin
                    byte_cnt <= '0;
                    pkt_cnt  <= '0;
                end
            end
        end
    end

    // R4
    byte_within_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> (byte_cnt <= byte_allow));

    // R6
    pkt_within_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && chk_pkt) |-> (pkt_cnt <= pkt_allow));

    // R8
    drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_pass && !$past(tick) && !$past(clear))
        |-> (byte_cnt == $past(byte_cnt) && pkt_cnt == $past(pkt_cnt)));

    // R9
    tick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !frm_valid) |=> (byte_cnt == '0 && pkt_cnt == '0));

endmodule

// File: rtl/port_rate_limiter.sv
module port_rate_limiter
    import rl_pkg::*;
#(
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned WINDOW_US = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_tick,
    input  logic [6:0]       rate_code,
    input  logic             pkt_mode,
    input  logic             gig_speed,
    input  logic             frm_valid,
    input  logic [LEN_W-1:0] frm_len,
    output logic             dec_valid,
    output logic             dec_pass
);

    rl_state_e st_q, st_nx;
    rl_cfg_t   cfg, cfg_q;

    logic        dec_unlim;
    logic [31:0] dec_kbps;
    logic [31:0] dec_pps;
    logic [CNT_W-1:0] byte_allow;
    logic [CNT_W-1:0] pkt_allow;

    logic do_load;
    logic win_open;
    logic win_bypass;

    assign cfg = '{code: rate_code, pkt_mode: pkt_mode, gig: gig_speed};

    rl_code_decode u_decode (
        .cfg       (cfg),
        .unlimited (dec_unlim),
        .kbps      (dec_kbps),
        .pps       (dec_pps)
    );

    rl_allow_conv #(
        .CNT_W     (CNT_W),
        .WINDOW_US (WINDOW_US)
    ) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (do_load),
        .kbps       (dec_kbps),
        .pps        (dec_pps),
        .byte_allow (byte_allow),
        .pkt_allow  (pkt_allow)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_LOAD;
            cfg_q <= '0;
        end else begin
            st_q <= st_nx;
            if (do_load) cfg_q <= cfg;
        end
    end

    // Transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_LOAD:   st_nx = dec_unlim ? ST_BYPASS : ST_OPEN;
            ST_OPEN:   if (cfg != cfg_q) st_nx = ST_LOAD;
            ST_BYPASS: if (cfg != cfg_q) st_nx = ST_LOAD;
            default:   st_nx = ST_LOAD;
        endcase
    end

    // State outputs
    always_comb begin
        do_load    = 1'b0;
        win_open   = 1'b0;
        win_bypass = 1'b0;
        unique case (st_q)
            ST_LOAD:   do_load    = 1'b1;
            ST_OPEN:   win_open   = 1'b1;
            ST_BYPASS: win_bypass = 1'b1;
            default:   do_load    = 1'b1;
        endcase
    end

    rl_window_ctr #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (do_load),
        .win_open   (win_open),
        .win_bypass (win_bypass),
        .chk_pkt    (cfg_q.pkt_mode),
        .tick       (win_tick),
        .frm_valid  (frm_valid),
        .frm_len    (frm_len),
        .byte_allow (byte_allow),
        .pkt_allow  (pkt_allow),
        .dec_valid  (dec_valid),
        .dec_pass   (dec_pass)
    );

    // R1
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BYPASS && frm_valid) |=> (dec_valid && dec_pass));

    // R11
    load_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOAD && frm_valid) |=> (dec_valid && !dec_pass));

    // R11
    reload_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_LOAD && cfg != cfg_q) |=> (st_q == ST_LOAD));

    // R12
    pass_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_pass |-> dec_valid);

endmodule

// File: tb/port_rate_limiter_tb.sv
module port_rate_limiter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_tick = 1'b0;
    logic [6:0]  rate_code = 7'd0;
    logic        pkt_mode = 1'b0;
    logic        gig_speed = 1'b0;
    logic        frm_valid = 1'b0;
    logic [15:0] frm_len = 16'd0;
    logic        dec_valid;
    logic        dec_pass;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    port_rate_limiter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_tick  (win_tick),
        .rate_code (rate_code),
        .pkt_mode  (pkt_mode),
        .gig_speed (gig_speed),
        .frm_valid (frm_valid),
        .frm_len   (frm_len),
        .dec_valid (dec_valid),
        .dec_pass  (dec_pass)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int len, input bit tk, output bit ok);
        @(negedge clk);
        frm_valid = 1'b1;
        frm_len   = 16'(len);
        win_tick  = tk;
        @(negedge clk);
        frm_valid = 1'b0;
        win_tick  = 1'b0;
        if (!dec_valid) check("R12 dec_valid", 0, 1);
        ok = dec_pass;
    endtask

    task automatic set_cfg(input int code, input bit pm, input bit gig);
        @(negedge clk);
        rate_code = 7'(code);
        pkt_mode  = pm;
        gig_speed = gig;
        repeat (3) @(negedge clk);
    endtask

    // n frames must pass, frame n+1 must drop
    task automatic burst(input int len, input int n, input string req);
        int  passed = 0;
        bit  ok;
        bit  last = 1'b0;
        for (int i = 0; i <= n; i++) begin
            send(len, 1'b0, ok);
            if (ok) passed++;
            if (i == n) last = ok;
        end
        check({req, " passes"}, passed, n);
        check({req, " final drop"}, int'(last), 0);
    endtask

    task automatic t_reset();
        bit ok;
        repeat (3) @(negedge clk);
        check("R12 reset dec_valid", int'(dec_valid), 0);
        check("R12 reset dec_pass", int'(dec_pass), 0);
        // R11: frame presented in the first (ST_LOAD) cycle
        rst_n     = 1'b1;
        frm_valid = 1'b1;
        frm_len   = 16'd64;
        @(negedge clk);
        frm_valid = 1'b0;
        check("R12 valid after frame", int'(dec_valid), 1);
        check("R11 frame in load dropped", int'(dec_pass), 0);
    endtask

    task automatic t_bypass();
        bit ok;
        int passed = 0;
        set_cfg(0, 1'b0, 1'b0);
        for (int i = 0; i < 50; i++) begin send(1500, 1'b0, ok); if (ok) passed++; end
        check("R1 code 0 passes all", passed, 50);
        set_cfg(120, 1'b1, 1'b1);
        passed = 0;
        for (int i = 0; i < 50; i++) begin send(9000, 1'b0, ok); if (ok) passed++; end
        check("R10 reserved code unlimited", passed, 50);
    endtask

    task automatic t_coarse();
        bit ok;
        set_cfg(1, 1'b0, 1'b0);            // 12500 bytes
        burst(1000, 12, "R2 code1 10/100");
        send(500, 1'b0, ok);
        check("R4/R8 exact fill after drop", int'(ok), 1);
        send(1, 1'b0, ok);
        check("R4 one byte over", int'(ok), 0);
        set_cfg(2, 1'b0, 1'b0);            // R11 reload: fresh 25000 bytes
        burst(1000, 25, "R11 reload code2");
        set_cfg(1, 1'b0, 1'b1);            // 125000 bytes
        burst(10000, 12, "R2 code1 gig");
    endtask

    task automatic t_fine();
        bit ok;
        set_cfg(101, 1'b0, 1'b0);          // 800 bytes
        send(900, 1'b0, ok);
        check("R4 oversize frame", int'(ok), 0);
        burst(100, 8, "R3 code101");
        set_cfg(113, 1'b0, 1'b1);          // 8320 kbps -> 104000 bytes
        burst(8000, 13, "R3 code113 gig");
    endtask

    task automatic t_pkt();
        set_cfg(101, 1'b1, 1'b0);          // 6 pkts, 800 bytes
        burst(64, 6, "R5 pkt101");
        set_cfg(102, 1'b1, 1'b0);          // 12 pkts, 1600 bytes
        burst(200, 8, "R6 byte bound");
        set_cfg(103, 1'b1, 1'b1);          // 256 pkts, 24000 bytes
        burst(64, 256, "R5 pkt103 gig");
        set_cfg(1, 1'b1, 1'b0);            // 192 pkts, 12500 bytes
        burst(64, 192, "R7 pkt1 10/100");
        set_cfg(1, 1'b1, 1'b1);            // 1920 pkts, 125000 bytes
        burst(64, 1920, "R7 pkt1 gig");
    endtask

    task automatic t_tick();
        bit ok;
        set_cfg(1, 1'b0, 1'b0);
        burst(1000, 12, "R9 fill");
        send(1000, 1'b1, ok);
        check("R9 frame with tick", int'(ok), 1);
        burst(1000, 11, "R9 rest of window");
        @(negedge clk); win_tick = 1'b1;
        @(negedge clk); win_tick = 1'b0;
        burst(1000, 12, "R9 after lone tick");
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_coarse();
        t_fine();
        t_pkt();
        t_tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule